// File: doc/BRIEF.md
# Two-Bank Data Memory Decoder

This block is the data memory of a small 8-bit controller core. An access arrives as a 7-bit file offset taken from the instruction. A bank bit held in the status register widens that offset to an 8-bit location. Offset zero is a pseudo-register with no storage behind it. An access to offset zero uses the full 8-bit value of the file-select register as the location instead. Every resolved location goes to exactly one of three targets: a special-function register slot, a byte of general-purpose RAM, or an empty location.

Some heavily used special-function registers are a single physical register that is reached from both banks. All RAM offsets in bank 1 land on the same bytes as bank 0. Empty locations return zero. Reads are combinational from the address. Writes land on the rising clock edge. The peripherals that would normally sit behind the special-function slots are not modelled, so every slot is plain 8-bit storage.

Top module: `bank_regfile`

## Requirements
- R1: For a direct access (offset not 0), bit 5 of the status register (offset 03h) selects the bank: 0 gives location {0,offset} and 1 gives location {1,offset}.
- R2: Offsets 02h, 03h, 04h, 09h, 0Ah and 0Bh each name one physical register in both banks. A write through either bank is read back through the other.
- R3: Offsets 01h, 05h, 06h and 08h are separate registers in bank 0 and in bank 1. A write in one bank leaves the register at the same offset in the other bank unchanged.
- R4: RAM occupies offsets 0Ch–2Fh. Locations 8Ch–AFh reach the same bytes as 0Ch–2Fh.
- R5: Locations 07h, 30h–7Fh and B0h–FFh read as 0, and writes to them are discarded.
- R6: With the power-control parameter set (the default), location 87h is a storage register. With the parameter cleared, 87h behaves as an empty location.
- R7: An access at offset 00h uses the whole file-select register (offset 04h) as the location. Its bit 7 chooses the bank, and the status bank bit has no effect on it.
- R8: When the file-select register holds 00h or 80h, an access at offset 00h reads 0 and a write there changes nothing.
- R9: `rd_data` follows the address in the same cycle. A write takes effect at the rising edge only when `wr_en` is 1 and `rst` is 0.
- R10: A synchronous reset clears status bit 5 and the file-select register. RAM and all other registers keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dir_addr | input | 7 | File offset from the instruction |
| wr_en | input | 1 | Write strobe for the addressed location |
| wr_data | input | 8 | Byte to be written |
| rd_data | output | 8 | Byte at the resolved location, combinational |

## Verification
Read data is due in the same cycle as the address. The bench therefore drives the address and the write strobe just after a falling edge, then compares `rd_data` one time unit later, before the next rising edge. A write, including a write to the status or file-select register that moves the bank or the indirect pointer, shows only in the cycle after the edge that captured it. The reference model commits its own write at that edge. The next comparison then sees the new contents and the new address resolution. The reset clears only some bits, so the model tracks which bits are known and compares only those.

// File: rtl/bank_regfile_pkg.sv
package bank_regfile_pkg;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_SFR  = 2'd1,
    K_RAM  = 2'd2
  } kind_e;

  localparam int NSLOT = 15;

  typedef enum logic [3:0] {
    S_TMR  = 4'd0,
    S_PCL  = 4'd1,
    S_STAT = 4'd2,
    S_FSEL = 4'd3,
    S_PA   = 4'd4,
    S_PB   = 4'd5,
    S_CTL0 = 4'd6,
    S_RES  = 4'd7,
    S_PCH  = 4'd8,
    S_INT  = 4'd9,
    S_OPT  = 4'd10,
    S_DIRA = 4'd11,
    S_DIRB = 4'd12,
    S_PWR  = 4'd13,
    S_CTL1 = 4'd14
  } slot_e;

  typedef struct packed {
    logic  hit;
    slot_e slot;
  } slot_hit_t;

  // maps a low special-function offset plus bank to its physical slot
  function automatic slot_hit_t slot_of(input logic [3:0] off, input logic bank,
                                        input logic has_pwr);
    slot_hit_t r;
    r.hit  = 1'b1;
    r.slot = S_TMR;
    case (off)
      4'h1: r.slot = bank ? S_OPT  : S_TMR;
      4'h2: r.slot = S_PCL;
      4'h3: r.slot = S_STAT;
      4'h4: r.slot = S_FSEL;
      4'h5: r.slot = bank ? S_DIRA : S_PA;
      4'h6: r.slot = bank ? S_DIRB : S_PB;
      4'h7: begin
        r.slot = S_PWR;
        r.hit  = bank & has_pwr;
      end
      4'h8: r.slot = bank ? S_CTL1 : S_CTL0;
      4'h9: r.slot = S_RES;
      4'hA: r.slot = S_PCH;
      4'hB: r.slot = S_INT;
      default: r.hit = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rf_addr_resolve.sv
module rf_addr_resolve #(
  parameter int AW = 7
) (
  input  logic [AW-1:0] dir_addr,
  input  logic          bank_bit,
  input  logic [AW:0]   fsel,
  output logic [AW:0]   eff_addr,
  output logic          is_ind
);
  assign is_ind   = (dir_addr == '0);
  assign eff_addr = is_ind ? fsel : {bank_bit, dir_addr};
endmodule

// File: rtl/rf_decode.sv
module rf_decode
  import bank_regfile_pkg::*;
#(
  parameter int AW      = 7,
  parameter int RAM_LO  = 12,
  parameter int RAM_HI  = 47,
  parameter bit HAS_PWR = 1'b1,
  parameter int IW      = 6
) (
  input  logic [AW:0]   eff_addr,
  output kind_e         kind,
  output slot_e         slot,
  output logic [IW-1:0] ram_idx
);
  localparam logic [AW-1:0] LO = AW'(RAM_LO);
  localparam logic [AW-1:0] HI = AW'(RAM_HI);

  logic [AW-1:0] off;
  logic          bank;
  slot_hit_t     sh;

  assign off  = eff_addr[AW-1:0];
  assign bank = eff_addr[AW];
  assign sh   = slot_of(off[3:0], bank, HAS_PWR);

  always_comb begin
    kind    = K_NONE;
    slot    = sh.slot;
    ram_idx = IW'(off - LO);
    if (off >= LO && off <= HI) begin
      kind = K_RAM;
    end else if (off < LO && off != '0 && sh.hit) begin
      kind = K_SFR;
    end
  end
endmodule

// File: rtl/rf_sfr_store.sv
module rf_sfr_store
  import bank_regfile_pkg::*;
#(
  parameter int DW       = 8,
  parameter int BANK_BIT = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  slot_e         slot,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          stat_bank,
  output logic [DW-1:0] fsel
);
  logic [NSLOT-1:0][DW-1:0] q;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    if (i == int'(S_STAT)) begin : g_stat
      always_ff @(posedge clk) begin
        if (rst) q[i][BANK_BIT] <= 1'b0;
        else if (we && slot == slot_e'(i)) q[i] <= wdata;
      end
    end else if (i == int'(S_FSEL)) begin : g_fsel
      always_ff @(posedge clk) begin
        if (rst) q[i] <= '0;
        else if (we && slot == slot_e'(i)) q[i] <= wdata;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst && we && slot == slot_e'(i)) q[i] <= wdata;
      end
    end
  end

  assign rdata     = q[slot];
  assign stat_bank = q[S_STAT][BANK_BIT];
  assign fsel      = q[S_FSEL];
endmodule

// File: rtl/rf_ram.sv
module rf_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 36,
  parameter int IW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && int'(idx) < DEPTH) mem[idx] <= wdata;
  end

  assign rdata = (int'(idx) < DEPTH) ? mem[idx] : '0;
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
  import bank_regfile_pkg::*;
#(
  parameter int AW       = 7,
  parameter int DW       = 8,
  parameter int RAM_LO   = 12,
  parameter int RAM_HI   = 47,
  parameter int BANK_BIT = 5,
  parameter bit HAS_PWR  = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] dir_addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = RAM_HI - RAM_LO + 1;
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // named internal events for the checker
  logic [AW:0]   eff_addr;
  logic          is_ind;
  kind_e         tgt_kind;
  slot_e         tgt_slot;
  logic [IW-1:0] ram_idx;
  logic          stat_bank;
  logic [DW-1:0] fsr_q;
  logic [DW-1:0] sfr_rd, ram_rd;
  logic          sfr_we, ram_we;

  rf_addr_resolve #(.AW(AW)) u_res (
    .dir_addr (dir_addr),
    .bank_bit (stat_bank),
    .fsel     (fsr_q[AW:0]),
    .eff_addr (eff_addr),
    .is_ind   (is_ind)
  );

  rf_decode #(.AW(AW), .RAM_LO(RAM_LO), .RAM_HI(RAM_HI), .HAS_PWR(HAS_PWR), .IW(IW)) u_dec (
    .eff_addr (eff_addr),
    .kind     (tgt_kind),
    .slot     (tgt_slot),
    .ram_idx  (ram_idx)
  );

  assign sfr_we = wr_en && (tgt_kind == K_SFR);
  assign ram_we = wr_en && !rst && (tgt_kind == K_RAM);

  rf_sfr_store #(.DW(DW), .BANK_BIT(BANK_BIT)) u_sfr (
    .clk       (clk),
    .rst       (rst),
    .we        (sfr_we),
    .slot      (tgt_slot),
    .wdata     (wr_data),
    .rdata     (sfr_rd),
    .stat_bank (stat_bank),
    .fsel      (fsr_q)
  );

  rf_ram #(.DW(DW), .DEPTH(DEPTH), .IW(IW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .idx   (ram_idx),
    .wdata (wr_data),
    .rdata (ram_rd)
  );

  always_comb begin
    case (tgt_kind)
      K_SFR:   rd_data = sfr_rd;
      K_RAM:   rd_data = ram_rd;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/bank_regfile_chk.sv
module bank_regfile_chk
  import bank_regfile_pkg::*;
#(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] dir_addr,
  input logic          wr_en,
  input logic [DW-1:0] rd_data,
  input logic [AW:0]   eff_addr,
  input kind_e         tgt_kind,
  input logic          stat_bank,
  input logic [DW-1:0] fsr_q
);
  // R1
  bank_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (dir_addr != '0) |-> (eff_addr[AW] == stat_bank));

  // R7
  ind_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (dir_addr == '0) |-> (eff_addr == fsr_q[AW:0]));

  // R5
  hole_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (tgt_kind == K_NONE) |-> (rd_data == '0));

  // R8
  self_ref_chk: assert property (@(posedge clk) disable iff (rst)
    (dir_addr == '0 && fsr_q[AW-1:0] == '0) |-> (tgt_kind == K_NONE && rd_data == '0));

  // R9
  no_write_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(fsr_q) && $stable(stat_bank)));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (fsr_q == '0 && !stat_bank));
endmodule

bind bank_regfile bank_regfile_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .dir_addr  (dir_addr),
  .wr_en     (wr_en),
  .rd_data   (rd_data),
  .eff_addr  (eff_addr),
  .tgt_kind  (tgt_kind),
  .stat_bank (stat_bank),
  .fsr_q     (fsr_q)
);

// File: tb/bank_regfile_tb.sv
module bank_regfile_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b0;
  logic [6:0] dir_addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // behavioural model: one byte per physical location, plus known-bit masks
  logic [7:0] mem  [256];
  logic [7:0] kmsk [256];

  always #5 clk = ~clk;

  bank_regfile u_dut (
    .clk(clk), .rst(rst), .dir_addr(dir_addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  // physical key for a location, -1 when nothing is stored there
  function automatic int key_of(input int loc);
    int off = loc % 128;
    if (off == 0) return -1;
    if (off >= 12 && off <= 47) return off;
    if (off >= 48) return -1;
    if (off == 2 || off == 3 || off == 4 || off == 9 || off == 10 || off == 11) return off;
    if (off == 7) return (loc >= 128) ? loc : -1;
    return loc;
  endfunction

  function automatic int loc_of(input logic [6:0] a);
    if (a == 0) return int'(mem[4]);
    return (mem[3][5] ? 128 : 0) + int'(a);
  endfunction

  task automatic step(input logic r, input logic [6:0] a, input logic w,
                      input logic [7:0] d, input string tag);
    int k;
    logic [7:0] exp, msk;
    @(negedge clk);
    rst = r; dir_addr = a; wr_en = w; wr_data = d;
    #1;
    k   = key_of(loc_of(a));
    exp = (k < 0) ? 8'h00 : mem[k];
    msk = (k < 0) ? 8'hFF : kmsk[k];
    total++;
    if ((rd_data & msk) !== (exp & msk)) begin
      bad++;
      $display("FAIL %s addr=%02h actual=%02h expected=%02h mask=%02h", tag, a, rd_data, exp, msk);
    end
    @(posedge clk);
    if (r) begin
      mem[3][5] = 1'b0; kmsk[3][5] = 1'b1;
      mem[4] = 8'h00;   kmsk[4] = 8'hFF;
    end else if (w && k >= 0) begin
      mem[k] = d; kmsk[k] = 8'hFF;
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = '0; kmsk[i] = '0; end
    // R10: reset state
    step(1, 7'h03, 0, 8'h00, "R10");
    step(0, 7'h03, 0, 8'h00, "R10");
    step(0, 7'h04, 0, 8'h00, "R10");
    // known contents everywhere, bank 0 then bank 1
    for (int b = 0; b < 2; b++) begin
      step(0, 7'h03, 1, b ? 8'h20 : 8'h00, "R1");
      for (int o = 1; o < 48; o++)
        if (o != 3) step(0, 7'(o), 1, 8'(o * 7 + b * 91), "R1");
    end
    // R3: banked pairs stay distinct
    step(0, 7'h03, 1, 8'h00, "R3");
    step(0, 7'h01, 1, 8'h11, "R3");
    step(0, 7'h03, 1, 8'h20, "R3");
    step(0, 7'h01, 1, 8'h22, "R3");
    step(0, 7'h01, 0, 8'h00, "R3");
    step(0, 7'h03, 1, 8'h00, "R3");
    step(0, 7'h01, 0, 8'h00, "R3");
    // R2: shared register written in bank 1, read in bank 0
    step(0, 7'h03, 1, 8'h20, "R2");
    step(0, 7'h0A, 1, 8'h5A, "R2");
    step(0, 7'h03, 1, 8'h00, "R2");
    step(0, 7'h0A, 0, 8'h00, "R2");
    // R4: bank-1 RAM reaches bank-0 bytes
    step(0, 7'h03, 1, 8'h20, "R4");
    step(0, 7'h10, 1, 8'hC3, "R4");
    step(0, 7'h2F, 1, 8'h3C, "R4");
    step(0, 7'h03, 1, 8'h00, "R4");
    step(0, 7'h10, 0, 8'h00, "R4");
    step(0, 7'h2F, 0, 8'h00, "R4");
    // R5: holes read zero, writes discarded
    step(0, 7'h07, 1, 8'hFF, "R5");
    step(0, 7'h07, 0, 8'h00, "R5");
    step(0, 7'h30, 1, 8'hFF, "R5");
    step(0, 7'h7F, 0, 8'h00, "R5");
    // R6: power-control register present at 87h
    step(0, 7'h03, 1, 8'h20, "R6");
    step(0, 7'h07, 1, 8'h33, "R6");
    step(0, 7'h07, 0, 8'h00, "R6");
    step(0, 7'h50, 1, 8'h77, "R5");
    step(0, 7'h50, 0, 8'h00, "R5");
    // R7: indirect with status bank ignored
    step(0, 7'h03, 1, 8'h00, "R7");
    step(0, 7'h04, 1, 8'h87, "R7");
    step(0, 7'h00, 0, 8'h00, "R7");
    step(0, 7'h00, 1, 8'h44, "R7");
    step(0, 7'h04, 1, 8'h81, "R7");
    step(0, 7'h00, 0, 8'h00, "R7");
    step(0, 7'h04, 1, 8'h01, "R7");
    step(0, 7'h00, 0, 8'h00, "R7");
    // R8: indirect onto itself
    step(0, 7'h04, 1, 8'h80, "R8");
    step(0, 7'h00, 1, 8'hEE, "R8");
    step(0, 7'h00, 0, 8'h00, "R8");
    step(0, 7'h04, 0, 8'h00, "R8");
    step(0, 7'h04, 1, 8'h00, "R8");
    step(0, 7'h00, 1, 8'hEE, "R8");
    step(0, 7'h04, 0, 8'h00, "R8");
    // R9: write strobe low changes nothing
    step(0, 7'h20, 0, 8'h99, "R9");
    step(0, 7'h20, 0, 8'h00, "R9");
    step(0, 7'h04, 0, 8'h55, "R9");
    step(0, 7'h04, 0, 8'h00, "R9");
    // R10: reset keeps RAM and plain registers
    step(0, 7'h04, 1, 8'h9C, "R10");
    step(0, 7'h03, 1, 8'hFF, "R10");
    step(1, 7'h11, 1, 8'hAA, "R10");
    step(0, 7'h11, 0, 8'h00, "R10");
    step(0, 7'h03, 0, 8'h00, "R10");
    step(0, 7'h04, 0, 8'h00, "R10");
    step(0, 7'h0B, 0, 8'h00, "R10");
    // mixed traffic
    for (int n = 0; n < 3000; n++) begin
      logic [6:0] a = 7'($urandom_range(0, 60));
      string tg;
      if (a == 0) tg = "R7";
      else if (a >= 12 && a <= 47) tg = "R4";
      else if (a >= 48 || a == 7) tg = "R5";
      else tg = "R2";
      step(($urandom_range(0, 99) == 0), a, 1'($urandom_range(0, 1)), 8'($urandom), tg);
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule